// File: doc/BRIEF.md
# Alamouti Equivalent Channel Gain Unit

This block runs beside a two-transmit, two-receive space-time combiner in a multicarrier receiver. For every subcarrier it produces the real, non-negative gain of the channel that the combined sample has passed through. A later zero-forcing or MMSE equalizer divides by this gain or weights with it. The block takes the same streamed channel estimates as the combiner, one complex estimate per transmit/receive path and subcarrier, together with a flag that tells whether the current symbol is the first (even) or the second (odd) symbol of a space-time block.

Each path's estimate is turned into a squared magnitude. The magnitudes of each transmit antenna are summed over both receive antennas. A one-symbol delay line then pairs a transmit-1 term from one symbol with a transmit-2 term from the other symbol of the same block. All arithmetic is unsigned after squaring, and every narrowing step saturates. The result comes out at the same latency as the combined samples, so gain and sample stay aligned.

Top module: `alamouti_gain_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `gainOut` becomes 0 at that edge.
- R2: For subcarrier l of an even symbol n, the gain equals the sum over both receive antennas of |h(tx1,rx)(n,l)|² + |h(tx2,rx)(n+1,l)|², in the fixed-point form of R5.
- R3: For subcarrier l of an odd symbol n+1, the gain equals the sum over both receive antennas of |h(tx1,rx)(n+1,l)|² + |h(tx2,rx)(n,l)|², in the fixed-point form of R5.
- R4: Channel inputs applied in cycle c (captured at the following edge) give their gain at `gainOut` in cycle c+NUM_SUB+4, for even and odd symbols alike.
- R5: The inputs are two's complement with IN_FRAC=7 fraction bits. Each square keeps SQ_FRAC=8 fraction bits, rounded toward zero. re²+im² is halved (floor) into 7 fraction bits. The sum over the receive antennas is halved (floor) into 6 fraction bits. The final pair sum is halved (floor) into 5 fraction bits. All values after squaring are unsigned.
- R6: Every narrowing saturates at its largest code: the square at 4095, the magnitude sum at 2047, the antenna sum at 1023 and the output at 1023. An input of −512 on both parts of all paths therefore gives a gain of 1023.
- R7: `oddSym`=0 marks a sample of the even (first) symbol of a block and `oddSym`=1 marks the odd (second) symbol. The flag is held for NUM_SUB consecutive samples and then toggles, and a stream starts with an even symbol.
- R8: The delay memory is a free-running ring of exactly NUM_SUB samples. Back-to-back blocks therefore pair correctly with no gap or restart between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one subcarrier sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| oddSym | input | 1 | Symbol parity of the current sample (R7) |
| chTx1Rx1Re | input | IN_W | Real part of the tx1→rx1 estimate |
| chTx1Rx1Im | input | IN_W | Imaginary part of the tx1→rx1 estimate |
| chTx1Rx2Re | input | IN_W | Real part of the tx1→rx2 estimate |
| chTx1Rx2Im | input | IN_W | Imaginary part of the tx1→rx2 estimate |
| chTx2Rx1Re | input | IN_W | Real part of the tx2→rx1 estimate |
| chTx2Rx1Im | input | IN_W | Imaginary part of the tx2→rx1 estimate |
| chTx2Rx2Re | input | IN_W | Real part of the tx2→rx2 estimate |
| chTx2Rx2Im | input | IN_W | Imaginary part of the tx2→rx2 estimate |
| gainOut | output | OUT_W | Unsigned equivalent gain, OUT_FRAC fraction bits |

## Verification
A parity flag that is delayed by the wrong number of stages swaps the even and odd formulas. The swap shows at the very first paired output, NUM_SUB+4 cycles after the first even sample. A ring pointer that skips or wraps early pairs terms from different subcarriers or symbols, and the mismatch shows once the first block reaches the output. A missing saturation or a wrong shift shows as soon as the saturating and small-value symbols reach the output. Those symbols are placed early in the stream, so errors there appear within the second and third blocks.

// File: rtl/chgain_pkg.sv
package chgain_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic pairOdd;   // sample now at the pairing stage belongs to an odd symbol
    logic pipeFull;  // three edges have passed since reset
  } gain_ctl_t;

  localparam int NUM_TX = 2;
  localparam int NUM_RX = 2;
  localparam int NUM_PATH = NUM_TX * NUM_RX;

endpackage

// File: rtl/chgain_ring.sv
// Fixed-delay ring memory: returns the word written DEPTH cycles earlier.
module chgain_ring #(
  parameter int DEPTH = 672,
  parameter int W     = 10,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);

  logic [W-1:0] mem [DEPTH];

  assign dout = mem[idx];

  always_ff @(posedge clk) begin
    mem[idx] <= din;
  end

endmodule

// File: rtl/chgain_ctrl.sv
module chgain_ctrl
  import chgain_pkg::*;
#(
  parameter int NUM_SUB = 672,
  parameter int IDX_W   = $clog2(NUM_SUB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oddIn,
  output gain_ctl_t        ctl,
  output logic [IDX_W-1:0] ringIdx
);

  localparam int LAST = NUM_SUB - 1;

  logic [2:0] flagPipe;
  logic [1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flagPipe <= '0;
      fillCnt  <= '0;
      ringIdx  <= '0;
    end else begin
      flagPipe <= {flagPipe[1:0], oddIn};
      if (fillCnt != 2'd3) fillCnt <= fillCnt + 2'd1;
      ringIdx  <= (ringIdx == IDX_W'(LAST)) ? '0 : ringIdx + 1'b1;
    end
  end

  assign ctl.pairOdd  = flagPipe[2];
  assign ctl.pipeFull = (fillCnt == 2'd3);

  // R7: parity at the pairing stage is the input flag of three cycles ago
  a_r7_flag_align: assert property (@(posedge clk) disable iff (rst)
    ctl.pipeFull |-> (ctl.pairOdd == $past(oddIn, 3)));

  // R8: ring wraps after exactly NUM_SUB positions
  a_r8_ring_wrap: assert property (@(posedge clk) disable iff (rst)
    (ringIdx == IDX_W'(LAST)) |=> (ringIdx == '0));

  // R8: ring never skips a position
  a_r8_ring_step: assert property (@(posedge clk) disable iff (rst)
    (ringIdx != IDX_W'(LAST)) |=> (ringIdx == IDX_W'($past(ringIdx) + 1'b1)));

endmodule

// File: rtl/chgain_dp.sv
module chgain_dp
  import chgain_pkg::*;
#(
  parameter int NUM_SUB  = 672,
  parameter int IDX_W    = $clog2(NUM_SUB),
  parameter int IN_W     = 10,
  parameter int IN_FRAC  = 7,
  parameter int SQ_W     = 12,
  parameter int SQ_FRAC  = 8,
  parameter int A1_W     = 11,
  parameter int A1_FRAC  = 7,
  parameter int A2_W     = 10,
  parameter int A2_FRAC  = 6,
  parameter int OUT_W    = 10,
  parameter int OUT_FRAC = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  gain_ctl_t                    ctl,
  input  logic [IDX_W-1:0]             ringIdx,
  input  logic [NUM_PATH-1:0][IN_W-1:0] chRe,
  input  logic [NUM_PATH-1:0][IN_W-1:0] chIm,
  output logic [OUT_W-1:0]             gainOut
);

  localparam int PW      = 2 * IN_W;
  localparam int SQ_SH   = 2 * IN_FRAC - SQ_FRAC;
  localparam int A1_SH   = SQ_FRAC - A1_FRAC;
  localparam int A2_SH   = A1_FRAC - A2_FRAC;
  localparam int OUT_SH  = A2_FRAC - OUT_FRAC;
  localparam int SQ_MAX  = (1 << SQ_W) - 1;
  localparam int A1_MAX  = (1 << A1_W) - 1;
  localparam int A2_MAX  = (1 << A2_W) - 1;
  localparam int OUT_MAX = (1 << OUT_W) - 1;

  logic [NUM_PATH-1:0][SQ_W-1:0] sqRe, sqIm;
  logic [NUM_PATH-1:0][A1_W-1:0] mag;
  logic [NUM_TX-1:0][A2_W-1:0]   pTx, pDly;
  logic [OUT_W-1:0]              evenGain, oddGain, oddDly;

  // Stage 1 and 2: squared magnitude of each path
  for (genvar k = 0; k < NUM_PATH; k++) begin : g_path
    logic signed [IN_W-1:0] re, im;
    logic signed [PW-1:0]   prodRe, prodIm;
    logic [PW-1:0]          shRe, shIm;
    logic [SQ_W:0]          sumSq, sumSh;

    assign re     = chRe[k];
    assign im     = chIm[k];
    assign prodRe = PW'(re) * PW'(re);
    assign prodIm = PW'(im) * PW'(im);
    assign shRe   = $unsigned(prodRe) >> SQ_SH;
    assign shIm   = $unsigned(prodIm) >> SQ_SH;

    always_ff @(posedge clk) begin
      sqRe[k] <= (shRe > PW'(SQ_MAX)) ? SQ_W'(SQ_MAX) : shRe[SQ_W-1:0];
      sqIm[k] <= (shIm > PW'(SQ_MAX)) ? SQ_W'(SQ_MAX) : shIm[SQ_W-1:0];
    end

    assign sumSq = {1'b0, sqRe[k]} + {1'b0, sqIm[k]};
    assign sumSh = sumSq >> A1_SH;

    always_ff @(posedge clk) begin
      mag[k] <= (sumSh > (SQ_W+1)'(A1_MAX)) ? A1_W'(A1_MAX) : sumSh[A1_W-1:0];
    end
  end

  // Stage 3: per-transmitter sum over receive antennas, then one-symbol delay
  for (genvar t = 0; t < NUM_TX; t++) begin : g_tx
    logic [A1_W:0] accRx, accSh;

    assign accRx = {1'b0, mag[t*NUM_RX]} + {1'b0, mag[t*NUM_RX+1]};
    assign accSh = accRx >> A2_SH;

    always_ff @(posedge clk) begin
      pTx[t] <= (accSh > (A1_W+1)'(A2_MAX)) ? A2_W'(A2_MAX) : accSh[A2_W-1:0];
    end

    chgain_ring #(.DEPTH(NUM_SUB), .W(A2_W), .IDX_W(IDX_W)) i_line (
      .clk (clk),
      .idx (ringIdx),
      .din (pTx[t]),
      .dout(pDly[t])
    );
  end

  // Pairing across the two symbols of a block
  logic [A2_W:0] evSum, evSh, odSum, odSh;

  assign evSum    = {1'b0, pDly[0]} + {1'b0, pTx[1]};
  assign evSh     = evSum >> OUT_SH;
  assign evenGain = (evSh > (A2_W+1)'(OUT_MAX)) ? OUT_W'(OUT_MAX) : evSh[OUT_W-1:0];

  assign odSum    = {1'b0, pTx[0]} + {1'b0, pDly[1]};
  assign odSh     = odSum >> OUT_SH;
  assign oddGain  = (odSh > (A2_W+1)'(OUT_MAX)) ? OUT_W'(OUT_MAX) : odSh[OUT_W-1:0];

  chgain_ring #(.DEPTH(NUM_SUB), .W(OUT_W), .IDX_W(IDX_W)) i_oddLine (
    .clk (clk),
    .idx (ringIdx),
    .din (oddGain),
    .dout(oddDly)
  );

  // Stage 4: output select
  always_ff @(posedge clk) begin
    if (rst) gainOut <= '0;
    else     gainOut <= ctl.pairOdd ? evenGain : oddDly;
  end

  // R6: most negative input code squares to the top code
  a_r6_sq_sat: assert property (@(posedge clk) disable iff (rst)
    ($past(chRe[0]) == {1'b1, {(IN_W-1){1'b0}}}) |-> (sqRe[0] == SQ_W'(SQ_MAX)));

  // R6: two saturated magnitudes give a saturated antenna sum
  a_r6_sum_sat: assert property (@(posedge clk) disable iff (rst)
    ($past(mag[0]) == A1_W'(A1_MAX) && $past(mag[1]) == A1_W'(A1_MAX))
      |-> (pTx[0] == A2_W'(A2_MAX)));

  // R5: all-zero estimates give zero antenna sums three cycles later
  a_r5_zero_path: assert property (@(posedge clk) disable iff (rst)
    (ctl.pipeFull && $past(chRe == '0 && chIm == '0, 3)) |-> (pTx == '0));

endmodule

// File: rtl/alamouti_gain_unit.sv
module alamouti_gain_unit
  import chgain_pkg::*;
#(
  parameter int NUM_SUB  = 672,
  parameter int IN_W     = 10,
  parameter int IN_FRAC  = 7,
  parameter int SQ_W     = 12,
  parameter int SQ_FRAC  = 8,
  parameter int A1_W     = 11,
  parameter int A1_FRAC  = 7,
  parameter int A2_W     = 10,
  parameter int A2_FRAC  = 6,
  parameter int OUT_W    = 10,
  parameter int OUT_FRAC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oddSym,
  input  logic [IN_W-1:0]  chTx1Rx1Re,
  input  logic [IN_W-1:0]  chTx1Rx1Im,
  input  logic [IN_W-1:0]  chTx1Rx2Re,
  input  logic [IN_W-1:0]  chTx1Rx2Im,
  input  logic [IN_W-1:0]  chTx2Rx1Re,
  input  logic [IN_W-1:0]  chTx2Rx1Im,
  input  logic [IN_W-1:0]  chTx2Rx2Re,
  input  logic [IN_W-1:0]  chTx2Rx2Im,
  output logic [OUT_W-1:0] gainOut
);

  localparam int IDX_W = $clog2(NUM_SUB);

  gain_ctl_t                     ctl;
  logic [IDX_W-1:0]              ringIdx;
  logic [NUM_PATH-1:0][IN_W-1:0] chRe, chIm;

  // path index = tx * NUM_RX + rx (both zero based)
  assign chRe = {chTx2Rx2Re, chTx2Rx1Re, chTx1Rx2Re, chTx1Rx1Re};
  assign chIm = {chTx2Rx2Im, chTx2Rx1Im, chTx1Rx2Im, chTx1Rx1Im};

  chgain_ctrl #(.NUM_SUB(NUM_SUB), .IDX_W(IDX_W)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .oddIn  (oddSym),
    .ctl    (ctl),
    .ringIdx(ringIdx)
  );

  chgain_dp #(
    .NUM_SUB(NUM_SUB), .IDX_W(IDX_W),
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .SQ_W(SQ_W), .SQ_FRAC(SQ_FRAC),
    .A1_W(A1_W), .A1_FRAC(A1_FRAC), .A2_W(A2_W), .A2_FRAC(A2_FRAC),
    .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .ringIdx(ringIdx),
    .chRe   (chRe),
    .chIm   (chIm),
    .gainOut(gainOut)
  );

endmodule

// File: tb/test_alamouti_gain_unit.sv
module test_alamouti_gain_unit;

  localparam int ND   = 8;
  localparam int NSYM = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oddSym = 1'b0;
  logic signed [9:0] hRe [4];
  logic signed [9:0] hIm [4];
  logic [9:0] gainOut;

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    int    val;
    string tag;
  } item_t;

  item_t evenQ[$];
  item_t oddQ[$];
  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;
  int e1 [ND];
  int e2 [ND];

  alamouti_gain_unit #(.NUM_SUB(ND)) i_alamouti_gain_unit (
    .clk       (clk),
    .rst       (rst),
    .oddSym    (oddSym),
    .chTx1Rx1Re(hRe[0]), .chTx1Rx1Im(hIm[0]),
    .chTx1Rx2Re(hRe[1]), .chTx1Rx2Im(hIm[1]),
    .chTx2Rx1Re(hRe[2]), .chTx2Rx1Im(hIm[2]),
    .chTx2Rx2Re(hRe[3]), .chTx2Rx2Im(hIm[3]),
    .gainOut   (gainOut)
  );

  // Reference arithmetic taken from R5 and R6
  function automatic int sqT(int v);
    int r = (v * v) >>> 6;
    return (r > 4095) ? 4095 : r;
  endfunction

  function automatic int magT(int re, int im);
    int r = (sqT(re) + sqT(im)) >>> 1;
    return (r > 2047) ? 2047 : r;
  endfunction

  function automatic int antT(int a, int b);
    int r = (a + b) >>> 1;
    return (r > 1023) ? 1023 : r;
  endfunction

  function automatic int pickVal(int s);
    case (s)
      2:       return -512;
      3:       return 511;
      4:       return int'($urandom_range(0, 15)) - 8;
      5:       return 0;
      default: return int'($urandom_range(0, 1023)) - 512;
    endcase
  endfunction

  task automatic driveSym(int s);
    bit odd = (s % 2) == 1;
    int blk = s / 2;
    string tagE;
    string tagO;
    case (blk)
      0:       begin tagE = "R2";    tagO = "R3 R7"; end
      1:       begin tagE = "R6 R2"; tagO = "R6 R3"; end
      2:       begin tagE = "R5 R2"; tagO = "R5 R3"; end
      default: begin tagE = "R8 R2"; tagO = "R8 R3"; end
    endcase
    for (int l = 0; l < ND; l++) begin
      int p1;
      int p2;
      int m [4];
      @(negedge clk);
      oddSym = odd;
      for (int k = 0; k < 4; k++) begin
        int vr = pickVal(s);
        int vi = pickVal(s);
        hRe[k] = 10'(vr);
        hIm[k] = 10'(vi);
        m[k]   = magT(vr, vi);
      end
      p1 = antT(m[0], m[1]);
      p2 = antT(m[2], m[3]);
      if (!odd) begin
        e1[l] = p1;
        e2[l] = p2;
      end else begin
        // R2: even gain, due 4 cycles after the odd sample (R4)
        evenQ.push_back('{cyc + 4, antT(e1[l], p2), tagE});
        // R3: odd gain, due NUM_SUB+4 cycles after the odd sample (R4)
        oddQ.push_back('{cyc + ND + 4, antT(p1, e2[l]), tagO});
      end
    end
  endtask

  // Monitor: compares scoreboard items in their due cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (evenQ.size() > 0 && evenQ[0].due == cyc) begin
        nCmp++;
        if (gainOut !== 10'(evenQ[0].val)) begin
          nBad++;
          $display("FAIL %s (R4 alignment) even gain at cycle %0d: got %0d expected %0d",
                   evenQ[0].tag, cyc, gainOut, evenQ[0].val);
        end
        void'(evenQ.pop_front());
      end
      if (oddQ.size() > 0 && oddQ[0].due == cyc) begin
        nCmp++;
        if (gainOut !== 10'(oddQ[0].val)) begin
          nBad++;
          $display("FAIL %s (R4 alignment) odd gain at cycle %0d: got %0d expected %0d",
                   oddQ[0].tag, cyc, gainOut, oddQ[0].val);
        end
        void'(oddQ.pop_front());
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      hRe[k] = '0;
      hIm[k] = '0;
    end
    repeat (4) @(negedge clk);
    // R1: output cleared while reset is held
    for (int i = 0; i < 2; i++) begin
      nCmp++;
      if (gainOut !== 10'd0) begin
        nBad++;
        $display("FAIL R1 reset value: got %0d expected 0", gainOut);
      end
      @(negedge clk);
    end
    rst = 1'b0;
    for (int s = 0; s < NSYM; s++) driveSym(s);
    @(negedge clk);
    oddSym = 1'b0;
    for (int k = 0; k < 4; k++) begin
      hRe[k] = '0;
      hIm[k] = '0;
    end
    repeat (ND + 8) @(negedge clk);
    done = 1'b1;
    // R4: every expected item must have been matched in its cycle
    nCmp++;
    if (evenQ.size() != 0 || oddQ.size() != 0) begin
      nBad++;
      $display("FAIL R4 unmatched items: got %0d expected 0", evenQ.size() + oddQ.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL R4 watchdog expired: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule